// File: doc/BRIEF.md
# Interleaved Flit Check-Byte Encoder

This block sits in the transmit path of a high-speed serial link. It takes the protected part of a fixed 256-byte flit as a byte stream with valid/ready flow control and start/end markers. It forwards each byte unchanged and feeds it into one of three independent Reed-Solomon remainder generators, chosen by the byte's position in the flit. After the 250th protected byte it appends six check bytes, two from each generator. The receiver can then correct one bad byte in each of the three codewords.

Bytes are spread over the three codewords round-robin. Any two neighbouring bytes, which is any 16-bit burst inside one lane, therefore land in different codewords. A start marker in the middle of a flit throws the partial flit away and restarts counting at that byte. An end marker on any byte other than the last protected one also discards the flit, and no check bytes are sent for it.

Top module: `fec_flit_enc`

## Requirements
- R1: After reset no check bytes are pending. `out_chk` and `out_eof` are 0, `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.
- R2: Outside check emission, `in_ready` equals `out_ready`. Each input byte appears on `out_data` in the same cycle, unchanged, with `out_valid = in_valid`, `out_chk = 0`, and `out_sof` copying an accepted start marker.
- R3: The accepted byte that carries `in_sof` is position 0. Position p feeds only group p mod 3, so changing the bytes at positions 7 and 8 leaves both group-0 check bytes unchanged and alters groups 1 and 2.
- R4: Each group is a Reed-Solomon code over GF(2^8) with field polynomial 0x11D and generator (x+1)(x+a), where a = 0x02. The group's data bytes in order (first byte at the highest degree), followed by ECC[g][0] (the x^1 coefficient) and ECC[g][1] (the x^0 coefficient), form a word that is zero at x=1 and at x=a.
- R5: Once position 249 is accepted, the next six output beats carry `out_chk = 1` and hold ECC0[0], ECC1[0], ECC2[0], ECC0[1], ECC1[1], ECC2[1] in that order. `out_eof` is 1 only on the sixth of them.
- R6: While a check byte is offered and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value.
- R7: While check bytes are being emitted, `in_ready` is 0 and no input byte is taken.
- R8: A start marker accepted mid-flit drops the partial flit. That byte becomes position 0 and all three groups restart from zero.
- R9: An accepted end marker at any position other than 249 discards the flit. No check bytes follow, and the next accepted byte is position 0 with all groups cleared, even when it carries no start marker.
- R10: After the sixth check byte is taken, the next accepted byte is position 0 of a fresh flit, even without a start marker, and it may follow with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Encoder can take an input byte |
| in_data | input | 8 | Protected flit byte |
| in_sof | input | 1 | Byte is the first of a flit |
| in_eof | input | 1 | Byte is the last protected byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 8 | Forwarded byte or check byte |
| out_sof | output | 1 | Forwarded start marker |
| out_chk | output | 1 | Beat is a check byte |
| out_eof | output | 1 | Beat is the last check byte of the flit |

## Verification
The checker watches the framing and flow control on every cycle:
- input is blocked during check emission;
- a check beat follows the last protected byte;
- check bytes are held under back-pressure;
- exactly six check beats are sent, with the end marker on the last;
- position restarts after a start marker;
- no check bytes are sent after an early end marker.

The check byte values, their group order and the mapping of positions to groups are shown only by the bench. It compares each result against an independent syndrome-based solution for several data patterns and ready patterns. It also covers back-to-back flits and flits that follow an abort.

// File: rtl/fec_flit_pkg.sv
package fec_flit_pkg;

  typedef logic [7:0] gf_t;

  // Low byte of the field polynomial x^8+x^4+x^3+x^2+1.
  localparam gf_t GF_POLY_LO = 8'h1D;

  // Two-byte remainder of one group: hi is the x^1 term, lo is the x^0 term.
  typedef struct packed {
    gf_t hi;
    gf_t lo;
  } rs_par_t;

  // Multiply by the field generator.
  function automatic gf_t gf_xtime(gf_t a);
    gf_t r;
    r = {a[6:0], 1'b0};
    if (a[7]) r = r ^ GF_POLY_LO;
    return r;
  endfunction

  // General field multiply, shift and add.
  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_xtime(x);
    end
    return acc;
  endfunction

  // One data byte into a degree-2 remainder divider with generator x^2+g1*x+g0.
  function automatic rs_par_t rs_step(rs_par_t s, gf_t d, gf_t g1, gf_t g0);
    rs_par_t r;
    gf_t     fb;
    fb   = d ^ s.hi;
    r.hi = s.lo ^ gf_mul(fb, g1);
    r.lo = gf_mul(fb, g0);
    return r;
  endfunction

endpackage

// File: rtl/fec_pos_track.sv
module fec_pos_track #(
  parameter int PROT_BYTES = 250,
  parameter int NUM_GRP    = 3,
  localparam int POS_W     = $clog2(PROT_BYTES),
  localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sof,
  input  logic             eof,
  output logic [POS_W-1:0] eff_pos,
  output logic [GRP_W-1:0] eff_grp,
  output logic             last_evt,
  output logic             abort_evt
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PROT_BYTES - 1);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GRP - 1);

  logic [POS_W-1:0] pos_q;
  logic [GRP_W-1:0] grp_q;

  // A start marker forces the current byte to position 0, group 0.
  always_comb begin
    eff_pos = sof ? '0 : pos_q;
    eff_grp = sof ? '0 : grp_q;
  end

  assign last_evt  = acc & (eff_pos == LAST_POS);
  assign abort_evt = acc & eof & (eff_pos != LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      grp_q <= '0;
    end else if (acc) begin
      if (last_evt || abort_evt) begin
        pos_q <= '0;
        grp_q <= '0;
      end else begin
        pos_q <= eff_pos + POS_W'(1);
        grp_q <= (eff_grp == LAST_GRP) ? '0 : eff_grp + GRP_W'(1);
      end
    end
  end

endmodule

// File: rtl/fec_grp_lfsr.sv
module fec_grp_lfsr
  import fec_flit_pkg::*;
#(
  parameter logic [7:0] ROOT = 8'h02
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd,
  input  logic    restart,
  input  logic    flush,
  input  gf_t     d,
  output rs_par_t par
);

  // Generator (x+1)(x+ROOT) = x^2 + (1^ROOT)x + ROOT.
  localparam gf_t G1 = 8'h01 ^ ROOT;
  localparam gf_t G0 = ROOT;

  rs_par_t seed;
  assign seed = restart ? '0 : par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par <= '0;
    end else if (flush) begin
      par <= '0;
    end else if (upd) begin
      par <= rs_step(seed, d, G1, G0);
    end else if (restart) begin
      par <= '0;
    end
  end

endmodule

// File: rtl/fec_chk_seq.sv
module fec_chk_seq
  import fec_flit_pkg::*;
#(
  parameter int NUM_GRP = 3,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    adv,
  input  rs_par_t par [NUM_GRP],
  output logic    active,
  output gf_t     chk_byte,
  output logic    last_beat,
  output logic    done_evt
);

  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GRP - 1);

  logic [GRP_W-1:0] grp_sel;
  logic             byte_sel;

  // Order: first byte of every group, then second byte of every group.
  always_comb begin
    chk_byte = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_sel == GRP_W'(g)) chk_byte = byte_sel ? par[g].lo : par[g].hi;
    end
  end

  assign last_beat = active & byte_sel & (grp_sel == LAST_GRP);
  assign done_evt  = last_beat & adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      grp_sel  <= '0;
      byte_sel <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      grp_sel  <= '0;
      byte_sel <= 1'b0;
    end else if (active && adv) begin
      if (grp_sel == LAST_GRP) begin
        grp_sel <= '0;
        if (byte_sel) begin
          active   <= 1'b0;
          byte_sel <= 1'b0;
        end else begin
          byte_sel <= 1'b1;
        end
      end else begin
        grp_sel <= grp_sel + GRP_W'(1);
      end
    end
  end

endmodule

// File: rtl/fec_flit_enc.sv
module fec_flit_enc
  import fec_flit_pkg::*;
#(
  parameter int         FLIT_BYTES = 256,
  parameter int         NUM_GRP    = 3,
  parameter logic [7:0] ROOT       = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_chk,
  output logic       out_eof
);

  localparam int CHK_PER_GRP = 2;
  localparam int NUM_CHK     = NUM_GRP * CHK_PER_GRP;
  localparam int PROT_BYTES  = FLIT_BYTES - NUM_CHK;
  localparam int POS_W       = $clog2(PROT_BYTES);
  localparam int GRP_W       = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  // Named internal events, also used by the checker.
  logic             acc_evt;
  logic             last_evt;
  logic             abort_evt;
  logic             restart_evt;
  logic             chk_done_evt;
  logic             chk_active;
  logic             chk_last;
  logic [POS_W-1:0] eff_pos;
  logic [GRP_W-1:0] eff_grp;
  gf_t              chk_byte;
  rs_par_t          grp_par [NUM_GRP];

  assign in_ready    = ~chk_active & out_ready;
  assign acc_evt     = in_valid & in_ready;
  assign restart_evt = acc_evt & in_sof;

  fec_pos_track #(
    .PROT_BYTES (PROT_BYTES),
    .NUM_GRP    (NUM_GRP)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc_evt),
    .sof       (in_sof),
    .eof       (in_eof),
    .eff_pos   (eff_pos),
    .eff_grp   (eff_grp),
    .last_evt  (last_evt),
    .abort_evt (abort_evt)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic upd_g;
    assign upd_g = acc_evt & (eff_grp == GRP_W'(g));

    fec_grp_lfsr #(
      .ROOT (ROOT)
    ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (upd_g),
      .restart (restart_evt),
      .flush   (abort_evt | chk_done_evt),
      .d       (in_data),
      .par     (grp_par[g])
    );
  end

  fec_chk_seq #(
    .NUM_GRP (NUM_GRP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (last_evt),
    .adv       (out_ready),
    .par       (grp_par),
    .active    (chk_active),
    .chk_byte  (chk_byte),
    .last_beat (chk_last),
    .done_evt  (chk_done_evt)
  );

  assign out_valid = chk_active | in_valid;
  assign out_data  = chk_active ? chk_byte : in_data;
  assign out_sof   = ~chk_active & in_valid & in_sof;
  assign out_chk   = chk_active;
  assign out_eof   = chk_last;

endmodule

// File: rtl/fec_flit_enc_chk.sv
module fec_flit_enc_chk #(
  parameter int POS_W   = 8,
  parameter int NUM_CHK = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic             in_eof,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_chk,
  input logic             out_eof,
  input logic             acc_evt,
  input logic             last_evt,
  input logic             abort_evt,
  input logic             chk_active,
  input logic [POS_W-1:0] eff_pos
);

  logic [7:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_cnt <= '0;
    else if (!chk_active) beat_cnt <= '0;
    else if (out_ready) beat_cnt <= beat_cnt + 8'd1;
  end

  AST_PASS_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_active |-> (in_ready == out_ready) && (out_valid == in_valid) && !out_chk); // R2
  AST_LAST_TO_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> chk_active && out_valid && out_chk); // R5
  AST_EOF_IN_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_chk && out_valid); // R5
  AST_CHK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> beat_cnt == 8'(NUM_CHK - 1)); // R5
  AST_CHK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chk_active && !out_ready |=> chk_active && out_valid && $stable(out_data)); // R6
  AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    chk_active |-> !in_ready); // R7
  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && in_sof && !in_eof |=> in_sof || eff_pos == POS_W'(1)); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !chk_active && (in_sof || eff_pos == '0)); // R9
  AST_DONE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    chk_active && out_ready && out_eof |=> !chk_active && (in_sof || eff_pos == '0)); // R10
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_active && !in_valid |-> !out_valid); // R1

endmodule

bind fec_flit_enc fec_flit_enc_chk #(
  .POS_W   (POS_W),
  .NUM_CHK (NUM_CHK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sof     (in_sof),
  .in_eof     (in_eof),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_chk    (out_chk),
  .out_eof    (out_eof),
  .acc_evt    (acc_evt),
  .last_evt   (last_evt),
  .abort_evt  (abort_evt),
  .chk_active (chk_active),
  .eff_pos    (eff_pos)
);

// File: tb/sim_fec_flit_enc.sv
`timescale 1ns/1ps
module sim_fec_flit_enc;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sof, in_eof;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_sof, out_chk, out_eof;
  logic [7:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  fec_flit_enc u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_chk(out_chk), .out_eof(out_eof)
  );

  localparam int NPROT = 250;

  // {expect all-zero checks, send start marker, kind, seed, ready mode}
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'd0, 8'd0,   8'd0},
    {1'b0, 1'b1, 8'd1, 8'd5,   8'd0},
    {1'b0, 1'b1, 8'd2, 8'd33,  8'd1},
    {1'b0, 1'b0, 8'd3, 8'hA7,  8'd2},
    {1'b0, 1'b1, 8'd2, 8'd91,  8'd3},
    {1'b0, 1'b0, 8'd1, 8'd250, 8'd1},
    {1'b0, 1'b1, 8'd3, 8'hFF,  8'd2}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] fb   [256];
  logic [7:0] expc [6];
  logic [7:0] got  [6];
  logic [7:0] base [6];

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Carry-less product followed by reduction modulo 0x11D.
  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    int p = 0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (int'(a) << i);
    for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (32'h11D << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] gen(int kind, int seed, int i);
    case (kind)
      0: return 8'h00;
      1, 4: return 8'((i + seed) & 255);
      2: return 8'(((i * 167) ^ (seed * 73) ^ ((i * i) >> 2)) & 255);
      default: return 8'(seed);
    endcase
  endfunction

  function automatic bit rdy(int mode, int step);
    case (mode)
      0: return 1'b1;
      1: return step[0];
      2: return (step % 3) != 0;
      default: return (step % 3) == 0;
    endcase
  endfunction

  // Check bytes from the two zero conditions of the codeword: at x=1 and x=2.
  task automatic model();
    logic [7:0] inv3 = 8'h00;
    for (int y = 1; y < 256; y++) if (gmul(8'h03, 8'(y)) == 8'h01) inv3 = 8'(y);
    for (int g = 0; g < 3; g++) begin
      logic [7:0] s = 8'h00, h = 8'h00, t, p1;
      for (int i = g; i < NPROT; i += 3) begin
        s = s ^ fb[i];
        h = gmul(h, 8'h02) ^ fb[i];
      end
      t = gmul(gmul(h, 8'h02), 8'h02);
      p1 = gmul(s ^ t, inv3);
      expc[g]     = p1;
      expc[g + 3] = s ^ p1;
    end
  endtask

  task automatic run_flit(int kind, int seed, int rmode, bit use_sof, string tag);
    int idx = 0, nout = 0, step = 0;
    int bad_pass = 0, bad_flag = 0, acc_in_chk = 0, hold_seen = 0, hold_bad = 0;
    logic [7:0] od [256];
    logic       oc [256];
    logic       oe [256];
    logic       os [256];
    for (int i = 0; i < NPROT; i++) fb[i] = gen(kind, seed, i);
    if (kind == 4) begin
      fb[7] = fb[7] ^ 8'h5A;
      fb[8] = fb[8] ^ 8'hC3;
    end
    model();
    while (nout < 256 && step < 4000) begin
      @(negedge clk);
      out_ready = rdy(rmode, step);
      in_valid  = 1'b1;
      if (idx < NPROT) begin
        in_data = fb[idx];
        in_sof  = use_sof && (idx == 0);
        in_eof  = (idx == NPROT - 1);
      end else begin
        in_data = 8'hEE;
        in_sof  = 1'b1;
        in_eof  = 1'b0;
      end
      #1;
      if (out_valid && !out_ready && out_chk && nout >= NPROT) begin
        hold_seen++;
        if (out_data !== expc[nout - NPROT]) hold_bad++;
      end
      if (out_valid && out_ready) begin
        od[nout] = out_data; oc[nout] = out_chk; oe[nout] = out_eof; os[nout] = out_sof;
        nout++;
      end
      if (in_valid && in_ready) begin
        if (idx < NPROT) idx++;
        else acc_in_chk++;
      end
      step++;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(step < 4000, {tag, " R5 flit completes"}, nout, 256);
    for (int i = 0; i < 256; i++) begin
      if (i >= nout) begin od[i] = 8'h00; oc[i] = 1'b0; oe[i] = 1'b0; os[i] = 1'b0; end
    end
    for (int i = 0; i < NPROT; i++) begin
      if (od[i] !== fb[i] || oc[i] !== 1'b0 || os[i] !== (use_sof && i == 0)) bad_pass++;
    end
    chk(bad_pass == 0, {tag, " R2 pass-through"}, bad_pass, 0);
    for (int k = 0; k < 6; k++) begin
      got[k] = od[NPROT + k];
      chk(od[NPROT + k] === expc[k], $sformatf("%s R4 R5 check byte %0d", tag, k),
          od[NPROT + k], expc[k]);
    end
    for (int i = 0; i < 256; i++) begin
      if (oe[i] !== (i == 255)) bad_flag++;
      if (i >= NPROT && oc[i] !== 1'b1) bad_flag++;
    end
    chk(bad_flag == 0, {tag, " R5 marker placement"}, bad_flag, 0);
    chk(acc_in_chk == 0, {tag, " R7 input blocked"}, acc_in_chk, 0);
    if (hold_seen > 0) chk(hold_bad == 0, {tag, " R6 held check byte"}, hold_bad, 0);
  endtask

  // Streams n bytes with ready high and no output checks; optional end marker on the last byte.
  task automatic send_raw(int n, int kind, int seed, bit eof_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      in_valid  = 1'b1;
      in_data   = gen(kind, seed, i);
      in_sof    = (i == 0);
      in_eof    = eof_last && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    in_data = 8'h00; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: state after reset
    @(negedge clk); #1;
    chk(out_chk == 1'b0 && out_eof == 1'b0, "R1 no check pending", {out_chk, out_eof}, 0);
    chk(out_valid == 1'b0, "R1 idle output", out_valid, 0);
    chk(in_ready == 1'b1, "R1 ready follows", in_ready, 1);
    @(negedge clk); out_ready = 1'b0; #1;
    chk(in_ready == 1'b0, "R1 ready follows low", in_ready, 0);
    out_ready = 1'b1;

    // Vector table: back-to-back flits, some without a start marker (R10)
    for (int v = 0; v < NV; v++) begin
      run_flit(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), VEC[v][24],
               $sformatf("vec%0d%s", v, VEC[v][24] ? "" : " R10"));
      if (VEC[v][25]) begin
        int nz = 0;
        for (int k = 0; k < 6; k++) if (got[k] != 8'h00) nz++;
        chk(nz == 0, "R4 zero data gives zero checks", nz, 0);
      end
    end

    // R3: adjacent bytes 7 and 8 touch only groups 1 and 2
    run_flit(1, 0, 0, 1'b1, "base R3");
    for (int k = 0; k < 6; k++) base[k] = got[k];
    run_flit(4, 0, 0, 1'b1, "burst R3");
    chk(got[0] == base[0] && got[3] == base[3], "R3 group 0 unchanged",
        {got[0], got[3]}, {base[0], base[3]});
    chk(got[1] != base[1] || got[4] != base[4], "R3 group 1 changed",
        {got[1], got[4]}, {base[1], base[4]});
    chk(got[2] != base[2] || got[5] != base[5], "R3 group 2 changed",
        {got[2], got[5]}, {base[2], base[5]});

    // R8: start marker mid-flit restarts the flit
    send_raw(100, 2, 9, 1'b0);
    run_flit(2, 17, 1, 1'b1, "R8 after partial");

    // R9: early end marker discards the flit, no check bytes follow
    send_raw(50, 3, 77, 1'b1);
    begin
      int seen = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk); #1;
        if (out_valid || out_chk) seen++;
      end
      chk(seen == 0, "R9 no check bytes after abort", seen, 0);
    end
    run_flit(1, 40, 2, 1'b0, "R9 after abort");

    // R9: end marker together with start marker on a single byte also aborts
    send_raw(1, 3, 12, 1'b1);
    @(negedge clk); #1;
    chk(out_chk == 1'b0, "R9 single-byte abort", out_chk, 0);
    run_flit(2, 5, 0, 1'b0, "R9 after one-byte abort");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule